// File: doc/BRIEF.md
# Synthesizer Tuning Word Loader

This block takes a 40-bit tuning and control word for a direct digital synthesizer from a 32-bit host register port and sends it to the synthesizer over an 8-bit parallel bus. The host supplies the word in two writes. A low write stores bits 31:0. A high write supplies bits 39:32 and starts the load.

After the high write, the block presents five bytes on consecutive system clock cycles, most significant byte first. It generates a word-load clock whose rising edge falls in the middle of each byte cycle, so the synthesizer captures each byte half a cycle after it appears. One cycle after the last byte, a single-cycle frequency-update strobe tells the synthesizer to move the assembled 40 bits into its active register.

A busy flag covers the whole sequence. Any host write made while the flag is high is dropped.

Top module: `dds_word_loader`

## Requirements
- R1: After reset, `busy`, `freqUpdate`, `wordClk` and `byteOut` are all 0.
- R2: A write with `hostWr`=1 and `hostHiSel`=0 while idle stores `hostData[31:0]` as word bits 31:0 and does not start a load; `busy` stays 0.
- R3: A write with `hostWr`=1 and `hostHiSel`=1 while idle takes `hostData[7:0]` as word bits 39:32, ignores `hostData[31:8]`, and raises `busy` at that same clock edge.
- R4: Starting in the cycle after the start edge, `byteOut` carries exactly five bytes, one per system clock cycle, in the order bits 39:32, 31:24, 23:16, 15:8, 7:0.
- R5: During each byte cycle, `wordClk` is low while `clk` is high and high while `clk` is low, so it rises half a cycle after the byte appears. Outside byte cycles `wordClk` is low.
- R6: `byteOut` is 0 in every cycle that is not a byte cycle.
- R7: `freqUpdate` is high for exactly one cycle, the cycle right after the fifth byte, and is low at all other times.
- R8: `busy` stays high from the start edge through the update cycle and falls together with `freqUpdate`.
- R9: Host writes of either kind made while `busy` is high are ignored. They neither change the stored word nor start another load.
- R10: The stored low 32 bits persist across loads, so a high write alone reloads them together with new bits 39:32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWr | input | 1 | Host write strobe, one cycle per write |
| hostHiSel | input | 1 | 0 selects the low 32 bits, 1 selects bits 39:32 and starts a load |
| hostData | input | 32 | Host write data |
| busy | output | 1 | Load in progress |
| byteOut | output | 8 | Parallel byte to the synthesizer |
| wordClk | output | 1 | Word-load clock; byte is captured on its rising edge |
| freqUpdate | output | 1 | One-cycle strobe that commits the loaded word |

## Verification
The assertions assume that `hostWr` is a clean single-cycle strobe sampled on the rising clock edge and that `hostHiSel` and `hostData` are stable around that edge. They also assume the host may write at any time, busy or not. The bench changes every input on the falling clock edge and holds each write for exactly one cycle. Some writes are aimed deliberately into the busy window, so the rule that busy-time writes are dropped is exercised, not just assumed. Outputs are sampled one nanosecond after each edge, which observes both phases of the word-load clock.

// File: rtl/dds_loader_pkg.sv
package dds_loader_pkg;

  // Strobes from the sequencer to the word datapath
  typedef struct packed {
    logic loadLo;   // store low host word
    logic launch;   // capture full word, start sequence
    logic shift;    // advance to next byte
    logic active;   // a byte is on the bus this cycle
  } ldStrobe_t;

endpackage

// File: rtl/dds_loader_ctrl.sv
module dds_loader_ctrl
  import dds_loader_pkg::*;
#(
  parameter int NUM_BYTES = 5
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      hostWr,
  input  logic      hostHiSel,
  output ldStrobe_t str,
  output logic      busy,
  output logic      freqUpdate
);

  localparam int CNT_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NUM_BYTES - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_UPD} ldState_t;

  ldState_t        state, stateNext;
  logic [CNT_W-1:0] byteCnt;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (hostWr && hostHiSel) stateNext = ST_SEND;
      ST_SEND: if (byteCnt == LAST_IDX) stateNext = ST_UPD;
      ST_UPD:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      byteCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_SEND) byteCnt <= byteCnt + 1'b1;
      else                  byteCnt <= '0;
    end
  end

  always_comb begin
    str.loadLo = (state == ST_IDLE) && hostWr && !hostHiSel;
    str.launch = (state == ST_IDLE) && hostWr && hostHiSel;
    str.shift  = (state == ST_SEND);
    str.active = (state == ST_SEND);
  end

  assign busy       = (state != ST_IDLE);
  assign freqUpdate = (state == ST_UPD);

  // R7
  upd_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    freqUpdate |=> !freqUpdate);

  // R4
  last_byte_then_upd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (str.active && byteCnt == LAST_IDX) |=> freqUpdate);

  // R8
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(freqUpdate));

  // R3
  launch_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.launch |=> (busy && str.active));

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(str.loadLo || str.launch));

endmodule

// File: rtl/dds_loader_dpath.sv
module dds_loader_dpath
  import dds_loader_pkg::*;
#(
  parameter int HOST_W = 32,
  parameter int WORD_W = 40,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ldStrobe_t         str,
  input  logic [HOST_W-1:0] hostData,
  output logic [BYTE_W-1:0] byteOut
);

  localparam int HI_W = WORD_W - HOST_W;

  logic [HOST_W-1:0] loReg;
  logic [WORD_W-1:0] shiftWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loReg     <= '0;
      shiftWord <= '0;
    end else begin
      if (str.loadLo) loReg <= hostData;
      if (str.launch)     shiftWord <= {hostData[HI_W-1:0], loReg};
      else if (str.shift) shiftWord <= shiftWord << BYTE_W;
    end
  end

  assign byteOut = str.active ? shiftWord[WORD_W-1 -: BYTE_W] : '0;

  // R3
  first_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.launch |=> (byteOut == $past(hostData[BYTE_W-1:0])));

  // R10
  lo_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !str.loadLo |=> (loReg == $past(loReg)));

endmodule

// File: rtl/dds_word_loader.sv
module dds_word_loader
  import dds_loader_pkg::*;
#(
  parameter int HOST_W = 32,
  parameter int WORD_W = 40,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWr,
  input  logic              hostHiSel,
  input  logic [HOST_W-1:0] hostData,
  output logic              busy,
  output logic [BYTE_W-1:0] byteOut,
  output logic              wordClk,
  output logic              freqUpdate
);

  localparam int NUM_BYTES = WORD_W / BYTE_W;

  ldStrobe_t str;

  dds_loader_ctrl #(.NUM_BYTES(NUM_BYTES)) ctrl (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostHiSel(hostHiSel),
    .str(str), .busy(busy), .freqUpdate(freqUpdate)
  );

  dds_loader_dpath #(.HOST_W(HOST_W), .WORD_W(WORD_W), .BYTE_W(BYTE_W)) dpath (
    .clk(clk), .rstN(rstN), .str(str), .hostData(hostData), .byteOut(byteOut)
  );

  // Rising edge sits mid-cycle: half a period of setup and hold for each byte
  assign wordClk = str.active & ~clk;

  // R5
  wclk_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !wordClk);

  // R6
  byte_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy || freqUpdate) |-> (byteOut == '0));

endmodule

// File: tb/dds_word_loader_test.sv
`timescale 1ns/1ps
module dds_word_loader_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWr = 1'b0;
  logic        hostHiSel = 1'b0;
  logic [31:0] hostData = '0;
  logic        busy;
  logic [7:0]  byteOut;
  logic        wordClk;
  logic        freqUpdate;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  dds_word_loader uut (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostHiSel(hostHiSel),
    .hostData(hostData), .busy(busy), .byteOut(byteOut),
    .wordClk(wordClk), .freqUpdate(freqUpdate)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // one-cycle host write, driven and released on falling edges
  task automatic hostWrite(input logic hi, input logic [31:0] data);
    @(negedge clk);
    hostWr = 1'b1; hostHiSel = hi; hostData = data;
    @(negedge clk);
    hostWr = 1'b0; hostHiSel = 1'b0; hostData = '0;
  endtask

  // called right after the start write returns (low phase of first byte cycle)
  task automatic checkSequence(input logic [39:0] word);
    logic [7:0] exp [5];
    for (int i = 0; i < 5; i++) exp[i] = word[39 - 8*i -: 8];
    #1;
    for (int i = 0; i < 5; i++) begin
      check("R4 byte low phase", byteOut, exp[i]);
      check("R5 wordClk high in low phase", wordClk, 1'b1);
      check("R8 busy during bytes", busy, 1'b1);
      check("R7 no early update", freqUpdate, 1'b0);
      @(posedge clk); #1;
      check("R5 wordClk low in high phase", wordClk, 1'b0);
      if (i < 4) check("R4 next byte", byteOut, exp[i+1]);
      else begin
        check("R7 update after last byte", freqUpdate, 1'b1);
        check("R6 byte bus zero in update", byteOut, 8'h00);
        check("R8 busy in update cycle", busy, 1'b1);
      end
      @(negedge clk); #1;
    end
    check("R5 wordClk low in update cycle", wordClk, 1'b0);
    @(posedge clk); #1;
    check("R7 update one cycle", freqUpdate, 1'b0);
    check("R8 busy falls with update", busy, 1'b0);
    check("R6 byte bus zero when idle", byteOut, 8'h00);
    check("R5 wordClk idle low", wordClk, 1'b0);
  endtask

  task automatic testReset();
    #1;
    check("R1 busy", busy, 1'b0);
    check("R1 freqUpdate", freqUpdate, 1'b0);
    check("R1 wordClk", wordClk, 1'b0);
    check("R1 byteOut", byteOut, 8'h00);
  endtask

  task automatic testBasicLoad();
    hostWrite(1'b0, 32'h89AB_CDEF);
    #1;
    check("R2 low write keeps idle", busy, 1'b0);
    check("R2 no bytes after low write", byteOut, 8'h00);
    hostWrite(1'b1, 32'hFFFF_FF45);   // R3 upper host bits ignored
    checkSequence(40'h45_89AB_CDEF);
  endtask

  task automatic testPatterns();
    hostWrite(1'b0, 32'h0000_0000);
    hostWrite(1'b1, 32'h0000_00FF);
    checkSequence(40'hFF_0000_0000);
    hostWrite(1'b0, 32'hA5A5_5A5A);
    hostWrite(1'b1, 32'h1234_5600);
    checkSequence(40'h00_A5A5_5A5A);
  endtask

  task automatic testBusyIgnore();
    hostWrite(1'b0, 32'h1122_3344);
    hostWrite(1'b1, 32'h0000_0077);
    // writes inside the busy window must be dropped
    @(negedge clk);
    hostWr = 1'b1; hostHiSel = 1'b0; hostData = 32'hDEAD_BEEF;
    @(negedge clk);
    hostWr = 1'b1; hostHiSel = 1'b1; hostData = 32'h0000_00EE;
    @(negedge clk);
    hostWr = 1'b0; hostHiSel = 1'b0; hostData = '0;
    while (busy) @(negedge clk);
    repeat (3) begin
      @(negedge clk); #1;
      check("R9 no extra load", busy, 1'b0);
      check("R9 no extra update", freqUpdate, 1'b0);
    end
    // R10 high-only reload reuses the pre-busy low word
    hostWrite(1'b1, 32'h0000_0099);
    checkSequence(40'h99_1122_3344);
  endtask

  task automatic testBackToBack();
    hostWrite(1'b0, 32'h0102_0304);
    hostWrite(1'b1, 32'h0000_0005);
    checkSequence(40'h05_0102_0304);
    // start again on the first idle cycle; R10 low word retained
    hostWrite(1'b1, 32'h0000_0006);
    checkSequence(40'h06_0102_0304);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    testBasicLoad();
    testPatterns();
    testBusyIgnore();
    testBackToBack();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule